// File: doc/BRIEF.md
# Maskable Clear-On-Read Interrupt Controller

This block collects a vector of status-change events and turns them into one interrupt line. Every rising edge on an event input latches a status bit. Each status bit has its own enable bit. While any latched status bit has its enable set, the interrupt line is asserted. The polarity of that line is programmable, and after reset the line is active low.

Software reaches the block through a small register port that has separate read and write strobes. One 16-bit interrupt register holds the enables in its upper byte and the latched status in its lower byte. Reading that register returns the status as it was and clears it in the same access. A second register holds the polarity selector. The sources of the events and the serial management link that carries register traffic both sit outside this block.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all enable and status bits are zero, polarity is active low, `irq_pin` is 1 and `reg_rdata` is 0.
- R2: A write strobe to address 27 loads the enable bits from `reg_wdata[15:8]`, where bit 8+k enables event k. A later read of address 27 returns them in bits 15:8.
- R3: A rising edge on `evt_i[k]` (low in one cycle, high in the next) sets status bit k. That bit appears as bit k of address 27. It stays set, whatever the input does, until a clearing read. An input held high does not set the bit again.
- R4: A read strobe to address 27 clears every status bit from the next cycle on. A read of any other address leaves the status unchanged.
- R5: If a rising event edge arrives in the same cycle as a clearing read, the status bit for that event ends up set.
- R6: `reg_rdata` is updated in the cycle after a read strobe and then holds. For address 27 it carries the enables and the status as they were before the clear.
- R7: The interrupt is active when some status bit k and enable bit 8+k are both set. With polarity 0, `irq_pin` is 0 while the interrupt is active and 1 otherwise. With polarity 1 it is the reverse.
- R8: A write to address 27 never changes the status bits, whatever `reg_wdata[7:0]` holds.
- R9: Bit 14 of address 31 is the polarity, where 1 means active high. Writes there change only that bit. A read of address 31 returns the polarity in bit 14 and zero in all other bits.
- R10: A read of any address other than 27 or 31 returns zero. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event inputs, synchronous to clk |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_rdata | output | 16 | Read data, registered |
| irq_pin | output | 1 | Interrupt line, programmable polarity |

## Verification
The assertions assume that the event inputs are already synchronous to `clk` and that `reg_addr` and `reg_wdata` are valid in every cycle in which a strobe is high. A read and a write may share a cycle. The bench changes every input on the falling clock edge and holds it for a whole cycle. A single event pulse therefore always gives exactly one rising edge that the block can see. The bench drives events low during reset, so no edge is seen at reset release. It sweeps every enable mask against every event line under both polarities, and it also drives an event edge in the same cycle as a clearing read.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_IRQ  = 2'd1,
      SEL_CTRL = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned N_EVT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             clr_i,
   output logic [N_EVT-1:0] evt_prev_o,
   output logic [N_EVT-1:0] stat_o
);
   for (genvar k = 0; k < N_EVT; k++) begin : g_bit
      logic prev_q;
      logic stat_q;
      logic rise;

      assign rise = evt_i[k] & ~prev_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
         end else begin
            prev_q <= evt_i[k];
            // an edge beats a simultaneous clear so no event is dropped
            stat_q <= (stat_q & ~clr_i) | rise;
         end
      end

      assign evt_prev_o[k] = prev_q;
      assign stat_o[k]     = stat_q;
   end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_pkg::*;
#(
   parameter int unsigned N_EVT     = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned IRQ_ADDR  = 27,
   parameter int unsigned CTRL_ADDR = 31,
   parameter int unsigned POL_BIT   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   input  logic [N_EVT-1:0]  stat_i,
   output logic [N_EVT-1:0]  en_o,
   output logic              pol_o,
   output logic              clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned EN_LSB = DATA_W / 2;

   reg_sel_e          sel;
   logic [N_EVT-1:0]  en_q;
   logic              pol_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rdata_d;
   logic              unused_wdata;

   assign unused_wdata = ^wdata;

   always_comb begin
      if (addr == ADDR_W'(IRQ_ADDR))       sel = SEL_IRQ;
      else if (addr == ADDR_W'(CTRL_ADDR)) sel = SEL_CTRL;
      else                                 sel = SEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         pol_q <= 1'b0;
      end else if (wr) begin
         if (sel == SEL_IRQ)  en_q  <= wdata[EN_LSB +: N_EVT];
         if (sel == SEL_CTRL) pol_q <= wdata[POL_BIT];
      end
   end

   always_comb begin
      rdata_d = '0;
      case (sel)
         SEL_IRQ: begin
            rdata_d[EN_LSB +: N_EVT] = en_q;
            rdata_d[N_EVT-1:0]       = stat_i;
         end
         SEL_CTRL: rdata_d[POL_BIT] = pol_q;
         default:  rdata_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= rdata_d;
   end

   assign clr_o   = rd && (sel == SEL_IRQ);
   assign en_o    = en_q;
   assign pol_o   = pol_q;
   assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
   parameter int unsigned N_EVT   = 8,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] stat_i,
   input  logic [N_EVT-1:0] en_i,
   input  logic             pol_i,
   output logic             pin_o
);
   logic active;
   logic level;

   assign active = |(stat_i & en_i);
   assign level  = pol_i ? active : ~active;

   if (OUT_REG) begin : g_reg
      logic pin_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pin_q <= 1'b1;
         else        pin_q <= level;
      end
      assign pin_o = pin_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign pin_o      = level;
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int unsigned N_EVT     = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned IRQ_ADDR  = 27,
   parameter int unsigned CTRL_ADDR = 31,
   parameter int unsigned POL_BIT   = 14,
   parameter bit          OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        evt_i,
   input  logic [4:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [15:0]       reg_wdata,
   input  logic              reg_rd,
   output logic [15:0]       reg_rdata,
   output logic              irq_pin
);
   if (N_EVT != 8 || ADDR_W != 5 || DATA_W != 16) begin : g_bad_shape
      $error("port widths are fixed at 8 events, 5 address bits, 16 data bits");
   end
   if (N_EVT > DATA_W / 2) begin : g_bad_evt
      $error("N_EVT must fit in half the data word");
   end
   if (POL_BIT >= DATA_W) begin : g_bad_pol
      $error("POL_BIT outside the data word");
   end
   if (IRQ_ADDR == CTRL_ADDR || IRQ_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register addresses must be distinct and in range");
   end

   logic [N_EVT-1:0] stat_q;
   logic [N_EVT-1:0] evt_prev_q;
   logic [N_EVT-1:0] en_q;
   logic             pol_q;
   logic             clr;

   irq_status_bank #(.N_EVT(N_EVT)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .clr_i      (clr),
      .evt_prev_o (evt_prev_q),
      .stat_o     (stat_q)
   );

   irq_reg_port #(
      .N_EVT     (N_EVT),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .IRQ_ADDR  (IRQ_ADDR),
      .CTRL_ADDR (CTRL_ADDR),
      .POL_BIT   (POL_BIT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (reg_addr),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .rd      (reg_rd),
      .stat_i  (stat_q),
      .en_o    (en_q),
      .pol_o   (pol_q),
      .clr_o   (clr),
      .rdata_o (reg_rdata)
   );

   irq_pin_drive #(.N_EVT(N_EVT), .OUT_REG(OUT_REG)) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat_q),
      .en_i   (en_q),
      .pol_i  (pol_q),
      .pin_o  (irq_pin)
   );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
   parameter int unsigned N_EVT     = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned IRQ_ADDR  = 27,
   parameter int unsigned CTRL_ADDR = 31,
   parameter int unsigned POL_BIT   = 14,
   parameter bit          OUT_REG   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_EVT-1:0]  evt_i,
   input logic [N_EVT-1:0]  evt_prev,
   input logic [N_EVT-1:0]  stat,
   input logic [N_EVT-1:0]  en,
   input logic              pol,
   input logic [ADDR_W-1:0] addr,
   input logic              wr,
   input logic [DATA_W-1:0] wdata,
   input logic              rd,
   input logic [DATA_W-1:0] rdata,
   input logic              irq_pin
);
   localparam int unsigned EN_LSB = DATA_W / 2;

   logic [N_EVT-1:0] set_v;
   logic             clr_v;
   logic             wr_irq;
   logic             wr_ctrl;
   logic             want_pin;

   assign set_v    = evt_i & ~evt_prev;
   assign clr_v    = rd && (addr == ADDR_W'(IRQ_ADDR));
   assign wr_irq   = wr && (addr == ADDR_W'(IRQ_ADDR));
   assign wr_ctrl  = wr && (addr == ADDR_W'(CTRL_ADDR));
   assign want_pin = pol ? (|(stat & en)) : !(|(stat & en));

   p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_irq |=> en == $past(wdata[EN_LSB +: N_EVT]));

   p_status_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_v |=> ((stat & $past(stat)) == $past(stat)));

   p_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v && set_v == '0) |=> stat == '0);

   p_event_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_v) |=> ((stat & $past(set_v)) == $past(set_v)));

   p_read_old_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_v |=> rdata[N_EVT-1:0] == $past(stat));

   p_write_spares_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_irq && !clr_v && set_v == '0) |=> stat == $past(stat));

   p_polarity_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> pol == $past(wdata[POL_BIT]));

   if (OUT_REG) begin : g_pin_reg
      p_pin_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> irq_pin == $past(want_pin));
   end else begin : g_pin_comb
      p_pin_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
         irq_pin == want_pin);
   end
endmodule

bind irq_aggregator irq_aggregator_chk #(
   .N_EVT     (N_EVT),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .IRQ_ADDR  (IRQ_ADDR),
   .CTRL_ADDR (CTRL_ADDR),
   .POL_BIT   (POL_BIT),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_i    (evt_i),
   .evt_prev (evt_prev_q),
   .stat     (stat_q),
   .en       (en_q),
   .pol      (pol_q),
   .addr     (reg_addr),
   .wr       (reg_wr),
   .wdata    (reg_wdata),
   .rd       (reg_rd),
   .rdata    (reg_rdata),
   .irq_pin  (irq_pin)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt_i = '0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_rdata;
   logic        irq_pin;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // bench model
   logic [7:0] m_en = '0;
   logic [7:0] m_st = '0;
   logic       m_pol = 1'b0;

   always #4 clk = ~clk;

   irq_aggregator i_irq_aggregator (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata),
      .irq_pin   (irq_pin)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic exp_pin();
      logic act;
      act = |(m_st & m_en);
      return m_pol ? act : ~act;
   endfunction

   task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      tick();
      reg_wr = 1'b0;
      if (a == 5'd27) m_en = d[15:8];
      if (a == 5'd31) m_pol = d[14];
   endtask

   task automatic reg_read(input logic [4:0] a, output logic [15:0] d);
      reg_addr = a;
      reg_rd   = 1'b1;
      tick();
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   function automatic logic [15:0] exp_rd(input logic [4:0] a);
      if (a == 5'd27) return {m_en, m_st};
      if (a == 5'd31) return {1'b0, m_pol, 14'd0};
      return 16'd0;
   endfunction

   task automatic read_check(input string req, input logic [4:0] a);
      logic [15:0] d;
      logic [15:0] e;
      e = exp_rd(a);
      reg_read(a, d);
      if (a == 5'd27) m_st = '0;
      check(req, d, e);
   endtask

   task automatic pulse(input int k);
      evt_i[k] = 1'b1;
      tick();
      evt_i[k] = 1'b0;
      tick();
      m_st[k] = 1'b1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] d;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 pin", {15'd0, irq_pin}, 16'd1);
      check("R1 rdata", reg_rdata, 16'd0);
      rst_n = 1'b1;
      tick();
      check("R1 pin after release", {15'd0, irq_pin}, 16'd1);
      read_check("R1 irq reg", 5'd27);
      read_check("R1 ctrl reg", 5'd31);

      // R2 and R8: every enable value, with junk in the low byte
      for (int e = 0; e < 256; e++) begin
         reg_write(5'd27, {8'(e), ~8'(e)});
         read_check("R2/R8 enable readback", 5'd27);
      end

      // R3 R4 R6 R7: every mask against every event, both polarities
      for (int p = 0; p < 2; p++) begin
         reg_write(5'd31, p[0] ? 16'h4000 : 16'h0000);
         for (int m = 0; m < 256; m++) begin
            reg_write(5'd27, {8'(m), 8'h00});
            for (int k = 0; k < 8; k++) begin
               pulse(k);
               check("R7 pin with event", {15'd0, irq_pin}, {15'd0, exp_pin()});
               read_check("R3/R6 status readback", 5'd27);
               check("R4/R7 pin after clear", {15'd0, irq_pin}, {15'd0, exp_pin()});
            end
         end
      end
      read_check("R4 cleared", 5'd27);

      // R3: level held high does not re-set after a clear
      reg_write(5'd31, 16'h0000);
      reg_write(5'd27, 16'hFF00);
      evt_i[6] = 1'b1;
      tick();
      tick();
      m_st[6] = 1'b1;
      read_check("R3 held level latched", 5'd27);
      tick();
      read_check("R3 held level no retrigger", 5'd27);
      evt_i[6] = 1'b0;
      tick();

      // R5: event edge in the same cycle as a clearing read
      pulse(0);
      reg_addr = 5'd27;
      reg_rd   = 1'b1;
      evt_i[3] = 1'b1;
      tick();
      reg_rd   = 1'b0;
      evt_i[3] = 1'b0;
      check("R5/R6 old status returned", reg_rdata, {m_en, 8'h01});
      m_st = 8'h08;
      tick();
      check("R5 pin still active", {15'd0, irq_pin}, 16'd0);
      read_check("R5 event kept", 5'd27);

      // R4: reading other addresses does not clear
      pulse(2);
      read_check("R4 ctrl read keeps status", 5'd31);
      read_check("R4 spare read keeps status", 5'd9);
      check("R4 pin still active", {15'd0, irq_pin}, {15'd0, exp_pin()});

      // R8: write with status bits set leaves them alone
      reg_write(5'd27, 16'h0000);
      check("R8 pin masked", {15'd0, irq_pin}, 16'd1);
      reg_write(5'd27, 16'hF0FF);
      read_check("R8 status kept", 5'd27);

      // R9: only the polarity bit is held
      reg_write(5'd31, 16'hFFFF);
      read_check("R9 ctrl readback", 5'd31);
      check("R9 active high idle", {15'd0, irq_pin}, 16'd0);
      pulse(4);
      check("R9 active high asserted", {15'd0, irq_pin}, 16'd1);
      reg_write(5'd31, 16'hBFFF);
      read_check("R9 ctrl cleared", 5'd31);
      check("R9 active low asserted", {15'd0, irq_pin}, 16'd0);

      // R10: unmapped addresses
      for (int a = 0; a < 32; a++) begin
         if (a != 27 && a != 31) begin
            reg_write(5'(a), 16'hFFFF);
            read_check("R10 unmapped read", 5'(a));
         end
      end
      read_check("R10 irq reg untouched", 5'd27);
      read_check("R10 ctrl reg untouched", 5'd31);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule